// File: doc/BRIEF.md
# Instruction Prefetch Unit with Branch Redirect

This block feeds a processor's decode stage with 32-bit instruction words read from an instruction memory or cache. It drives a read-only request/grant/response handshake toward memory. It tags every granted read with the address that was on the bus in its grant cycle. Returned words go into a small first-in first-out buffer together with their fetch address. Decode takes them through a valid/ready handshake. When memory grants one read and returns one word per cycle, decode receives one instruction per cycle.

A branch redirect replaces the fetch address in any cycle, including one in which a request is still waiting for its grant. The redirect empties the buffer. It also marks every read already granted as stale, and the responses to stale reads are thrown away when they come back. Fetching then continues from the redirect target with its two low address bits cleared. After reset the unit stays quiet until a first redirect supplies a start address.

Top module: `ifetch_prefetch`

## Requirements
- R1: After reset, and until the first redirect cycle, `mem_req_o` and `dec_valid_o` stay 0.
- R2: Once `mem_req_o` is 1 in a cycle with `mem_gnt_i` 0, it is still 1 in the next cycle. When no redirect occurs in that cycle, `mem_addr_o` is also unchanged in the next cycle.
- R3: In the cycle after a redirect cycle, `mem_addr_o` equals `redir_addr_i` with bits [1:0] cleared. This holds even when a request was pending without a grant, and that request stays asserted.
- R4: At most `MAX_OUT` (2) granted reads are awaiting a response. Granted-but-unanswered reads plus buffered words never exceed `DEPTH` (4). With decode stalled after a redirect, exactly 4 new reads are granted and then `mem_req_o` stays 0.
- R5: Every word handed to decode equals the data returned for the address that was on `mem_addr_o` in the grant cycle of that read, and `dec_pc_o` carries that address.
- R6: After each grant outside a redirect cycle, the next fetch address is the previous one plus 4.
- R7: A redirect empties the buffer. Responses to reads granted in or before the redirect cycle never reach decode, so the first word delivered afterwards has `dec_pc_o` equal to the aligned target.
- R8: `dec_valid_o` is 0 in any cycle in which `redir_valid_i` is 1.
- R9: Words reach decode in fetch order. With a grant and a response every cycle and `dec_ready_i` held at 1, one word is delivered per cycle.
- R10: While decode holds `dec_ready_i` at 0 and no redirect occurs, a presented word stays valid with `dec_pc_o` and `dec_word_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| redir_valid_i | input | 1 | Redirect fetching to `redir_addr_i` this cycle |
| redir_addr_i | input | 32 | Redirect target (half-word aligned; bits [1:0] are cleared) |
| mem_req_o | output | 1 | Read request to instruction memory |
| mem_addr_o | output | 32 | Word-aligned fetch address |
| mem_gnt_i | input | 1 | Memory accepted the request in this cycle |
| mem_rvalid_i | input | 1 | Response valid, one cycle per granted read, in grant order |
| mem_rdata_i | input | 32 | Response data |
| dec_valid_o | output | 1 | An instruction word is offered to decode |
| dec_ready_i | input | 1 | Decode accepts the offered word |
| dec_word_o | output | 32 | Offered instruction word |
| dec_pc_o | output | 32 | Fetch address of the offered word |

## Verification
A redirect can land in the same cycle as a grant, a returning response or both. The read granted in that cycle still carries the old address and must be counted among the stale reads it shares the cycle with. The bench provokes this by issuing redirects at varied offsets while memory grants and answers on pseudo-random cycles, sometimes with back-to-back redirects. A scoreboard of expected fetch addresses judges the outcome: the first delivered word after each redirect must carry the aligned target, and every word must match the memory model's content for its address.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

    localparam int unsigned XLEN = 32;

    typedef logic [XLEN-1:0] word_t;

    // One buffered fetch result: where it came from and what came back
    typedef struct packed {
        word_t pc;
        word_t insn;
    } fetch_entry_t;

    typedef enum logic {
        FETCH_IDLE = 1'b0,
        FETCH_RUN  = 1'b1
    } fetch_state_e;

    function automatic word_t word_align(input word_t a);
        return {a[XLEN-1:2], 2'b00};
    endfunction

    function automatic word_t next_word(input word_t a);
        return a + word_t'(4);
    endfunction

endpackage

// File: rtl/ifp_addr_gen.sv
module ifp_addr_gen
    import ifp_pkg::*;
#(
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned MAX_OUT = 2,
    parameter int unsigned CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             redir_valid_i,
    input  word_t            redir_addr_i,
    input  logic             gnt_i,
    input  logic [CNT_W-1:0] out_cnt_i,
    input  logic [CNT_W-1:0] fifo_cnt_i,
    output logic             req_o,
    output word_t            addr_o
);

    localparam logic [CNT_W:0]   DEPTH_W = (CNT_W + 1)'(DEPTH);
    localparam logic [CNT_W-1:0] OUT_CAP = CNT_W'(MAX_OUT);

    fetch_state_e   state_q;
    word_t          addr_q;
    logic [CNT_W:0] slots_used;
    logic           room;

    // Space is reserved for every granted read before it is issued
    always_comb begin
        slots_used = {1'b0, out_cnt_i} + {1'b0, fifo_cnt_i};
        room       = (out_cnt_i < OUT_CAP) && (slots_used < DEPTH_W);
        req_o      = (state_q == FETCH_RUN) && room;
        addr_o     = addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FETCH_IDLE;
            addr_q  <= '0;
        end else if (redir_valid_i) begin
            state_q <= FETCH_RUN;
            addr_q  <= word_align(redir_addr_i);
        end else if (req_o && gnt_i) begin
            addr_q  <= next_word(addr_q);
        end
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (req_o && !gnt_i) |=> req_o)
        else $error("request dropped before grant");

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (req_o && !gnt_i && !redir_valid_i) |=> $stable(addr_o))
        else $error("address moved while waiting for grant");

endmodule

// File: rtl/ifp_tracker.sv
module ifp_tracker
    import ifp_pkg::*;
#(
    parameter int unsigned MAX_OUT = 2,
    parameter int unsigned CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grant_i,
    input  word_t            grant_addr_i,
    input  logic             rvalid_i,
    input  logic             flush_i,
    output logic [CNT_W-1:0] out_cnt_o,
    output logic             resp_live_o,
    output word_t            resp_pc_o
);

    localparam int unsigned PTR_W = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(MAX_OUT - 1);

    word_t            tag_q [MAX_OUT];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] out_q, out_d, stale_q;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    // Reads complete in grant order; stale ones are always the oldest
    always_comb begin
        out_d       = out_q + CNT_W'(grant_i) - CNT_W'(rvalid_i);
        resp_live_o = rvalid_i && (stale_q == '0) && !flush_i;
        resp_pc_o   = tag_q[rd_q];
        out_cnt_o   = out_q;
    end

    for (genvar g = 0; g < MAX_OUT; g++) begin : g_tag
        always_ff @(posedge clk) begin
            if (grant_i && (wr_q == PTR_W'(g))) begin
                tag_q[g] <= grant_addr_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            rd_q    <= '0;
            out_q   <= '0;
            stale_q <= '0;
        end else begin
            if (grant_i)  wr_q <= ptr_step(wr_q);
            if (rvalid_i) rd_q <= ptr_step(rd_q);
            out_q <= out_d;
            if (flush_i) begin
                stale_q <= out_d;
            end else if (rvalid_i && (stale_q != '0)) begin
                stale_q <= stale_q - CNT_W'(1);
            end
        end
    end

    assert_outstanding_cap_R4: assert property (@(posedge clk) disable iff (rst)
        out_q <= CNT_W'(MAX_OUT))
        else $error("too many reads outstanding");

    assert_resp_owned_R5: assert property (@(posedge clk) disable iff (rst)
        rvalid_i |-> (out_q != '0))
        else $error("response without a granted read");

    assert_stale_bound_R7: assert property (@(posedge clk) disable iff (rst)
        stale_q <= out_q)
        else $error("stale count exceeds outstanding reads");

endmodule

// File: rtl/ifp_fifo.sv
module ifp_fifo
    import ifp_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             push_i,
    input  fetch_entry_t     push_data_i,
    input  logic             pop_i,
    output fetch_entry_t     head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             nonempty_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    fetch_entry_t     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        head_o     = slot_q[rd_q];
        count_o    = count_q;
        nonempty_o = (count_q != '0);
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_i && (wr_q == PTR_W'(s))) begin
                slot_q[s] <= push_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (push_i) wr_q <= ptr_step(wr_q);
            if (pop_i)  rd_q <= ptr_step(rd_q);
            count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (push_i && !flush_i) |-> ((count_q < FULL_CNT) || pop_i))
        else $error("push into a full buffer");

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> (count_q != '0))
        else $error("pop from an empty buffer");

endmodule

// File: rtl/ifetch_prefetch.sv
module ifetch_prefetch
    import ifp_pkg::*;
#(
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned MAX_OUT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        redir_valid_i,
    input  logic [31:0] redir_addr_i,
    output logic        mem_req_o,
    output logic [31:0] mem_addr_o,
    input  logic        mem_gnt_i,
    input  logic        mem_rvalid_i,
    input  logic [31:0] mem_rdata_i,
    output logic        dec_valid_o,
    input  logic        dec_ready_i,
    output logic [31:0] dec_word_o,
    output logic [31:0] dec_pc_o
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W:0] DEPTH_W = (CNT_W + 1)'(DEPTH);

    logic             grant;
    logic [CNT_W-1:0] out_cnt;
    logic [CNT_W-1:0] fifo_cnt;
    logic             resp_live;
    word_t            resp_pc;
    fetch_entry_t     push_entry;
    fetch_entry_t     head;
    logic             fifo_nonempty;
    logic             pop;

    always_comb begin
        grant      = mem_req_o && mem_gnt_i;
        push_entry = '{pc: resp_pc, insn: mem_rdata_i};
        // Nothing is handed over while a redirect empties the buffer
        dec_valid_o = fifo_nonempty && !redir_valid_i;
        pop         = dec_valid_o && dec_ready_i;
        dec_word_o  = head.insn;
        dec_pc_o    = head.pc;
    end

    ifp_addr_gen #(
        .DEPTH   (DEPTH),
        .MAX_OUT (MAX_OUT),
        .CNT_W   (CNT_W)
    ) addr_gen_i (
        .clk           (clk),
        .rst           (rst),
        .redir_valid_i (redir_valid_i),
        .redir_addr_i  (redir_addr_i),
        .gnt_i         (mem_gnt_i),
        .out_cnt_i     (out_cnt),
        .fifo_cnt_i    (fifo_cnt),
        .req_o         (mem_req_o),
        .addr_o        (mem_addr_o)
    );

    ifp_tracker #(
        .MAX_OUT (MAX_OUT),
        .CNT_W   (CNT_W)
    ) tracker_i (
        .clk          (clk),
        .rst          (rst),
        .grant_i      (grant),
        .grant_addr_i (mem_addr_o),
        .rvalid_i     (mem_rvalid_i),
        .flush_i      (redir_valid_i),
        .out_cnt_o    (out_cnt),
        .resp_live_o  (resp_live),
        .resp_pc_o    (resp_pc)
    );

    ifp_fifo #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) fifo_i (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (redir_valid_i),
        .push_i      (resp_live),
        .push_data_i (push_entry),
        .pop_i       (pop),
        .head_o      (head),
        .count_o     (fifo_cnt),
        .nonempty_o  (fifo_nonempty)
    );

    assert_budget_R4: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, out_cnt} + {1'b0, fifo_cnt}) <= DEPTH_W)
        else $error("outstanding plus buffered exceeds depth");

    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (rst)
        redir_valid_i |=> (fifo_cnt == '0))
        else $error("buffer not empty after redirect");

    assert_hold_head_R10: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o && !dec_ready_i && !redir_valid_i)
            |=> (fifo_nonempty && $stable(dec_pc_o) && $stable(dec_word_o)))
        else $error("offered word changed while decode stalled");

endmodule

// File: tb/ifetch_prefetch_tb_top.sv
`timescale 1ns/1ps
module ifetch_prefetch_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        redir_valid_i = 1'b0;
    logic [31:0] redir_addr_i = '0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_gnt_i = 1'b0;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        dec_valid_o;
    logic        dec_ready_i = 1'b0;
    logic [31:0] dec_word_o;
    logic [31:0] dec_pc_o;

    always #4 clk = ~clk;   // 125 MHz

    ifetch_prefetch dut_i (
        .clk           (clk),
        .rst           (rst),
        .redir_valid_i (redir_valid_i),
        .redir_addr_i  (redir_addr_i),
        .mem_req_o     (mem_req_o),
        .mem_addr_o    (mem_addr_o),
        .mem_gnt_i     (mem_gnt_i),
        .mem_rvalid_i  (mem_rvalid_i),
        .mem_rdata_i   (mem_rdata_i),
        .dec_valid_o   (dec_valid_o),
        .dec_ready_i   (dec_ready_i),
        .dec_word_o    (dec_word_o),
        .dec_pc_o      (dec_pc_o)
    );

    int unsigned total = 0;
    int unsigned bad   = 0;

    // 0: always, 1: pseudo-random, 2: never
    int gnt_mode = 0;
    int rv_mode  = 0;
    int rdy_mode = 0;

    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] pend[$];
    logic [31:0] exp_q[$];
    int unsigned new_grants = 0;
    int unsigned xfers = 0;
    int          bench_out = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h9E37_79B9;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory and decode-side model: sample at negedge, drive just after posedge
    initial begin
        logic        g;
        logic [31:0] ga;
        forever begin
            @(negedge clk);
            g  = mem_req_o && mem_gnt_i && !rst;
            ga = mem_addr_o;
            if (g && !redir_valid_i) new_grants++;
            if (!rst) begin
                bench_out = bench_out + (g ? 1 : 0) - (mem_rvalid_i ? 1 : 0);
                if (g) check(bench_out <= 2, "R4 outstanding", bench_out, 2);
            end
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (rst) begin
                pend.delete();
                bench_out = 0;
                mem_rvalid_i = 1'b0;
            end else begin
                if (g) pend.push_back(ga);
                if (pend.size() > 0 && (rv_mode == 0 || (rv_mode == 1 && (lfsr[5] | lfsr[9])))) begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = mem_word(pend.pop_front());
                end else begin
                    mem_rvalid_i = 1'b0;
                    mem_rdata_i  = 32'hDEAD_BEEF;
                end
            end
            mem_gnt_i   = (gnt_mode == 0) || (gnt_mode == 1 && (lfsr[0] | lfsr[3]));
            dec_ready_i = (rdy_mode == 0) || (rdy_mode == 1 && (lfsr[7] | lfsr[11]));
        end
    end

    // Scoreboard monitor: each accepted word against the expected fetch stream
    initial begin
        logic [31:0] e;
        forever begin
            @(negedge clk);
            if (!rst && dec_valid_o && dec_ready_i) begin
                xfers++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected word", dec_pc_o, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(dec_pc_o == e, "R9/R6/R7 pc order", dec_pc_o, e);
                    check(dec_word_o == mem_word(dec_pc_o), "R5 word matches grant address",
                          dec_word_o, mem_word(dec_pc_o));
                end
            end
        end
    end

    task automatic redirect(input logic [31:0] target);
        @(posedge clk);
        #1;
        redir_valid_i = 1'b1;
        redir_addr_i  = target;
        exp_q.delete();
        for (int i = 0; i < 600; i++) exp_q.push_back({target[31:2], 2'b00} + 32'(4 * i));
        new_grants = 0;
        @(negedge clk);
        check(dec_valid_o == 1'b0, "R8 valid low in redirect cycle", 32'(dec_valid_o), 0);
        @(posedge clk);
        #1;
        redir_valid_i = 1'b0;
        @(negedge clk);
        check(mem_addr_o == {target[31:2], 2'b00}, "R3 aligned target", mem_addr_o,
              {target[31:2], 2'b00});
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held_pc;
        int unsigned cnt;

        // R1: reset and idle before any redirect
        rst = 1'b1;
        wait_cycles(3);
        #1 rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(mem_req_o == 1'b0, "R1 no request before boot", 32'(mem_req_o), 0);
            check(dec_valid_o == 1'b0, "R1 no valid before boot", 32'(dec_valid_o), 0);
        end

        // R9: full-speed streaming, one word per cycle
        redirect(32'h0000_1000);
        wait_cycles(10);
        cnt = xfers;
        repeat (20) @(negedge clk);
        check((xfers - cnt) == 20, "R9 one word per cycle", xfers - cnt, 20);

        // R3: half-word and odd targets are word aligned
        redirect(32'h0000_2002);
        wait_cycles(8);
        redirect(32'h0000_2105);
        wait_cycles(8);

        // R4/R10: decode stalled, buffer fills with exactly 4 reads
        rdy_mode = 2;
        redirect(32'h0000_3000);
        wait_cycles(30);
        @(negedge clk);
        check(new_grants == 4, "R4 grants with decode stalled", new_grants, 4);
        check(mem_req_o == 1'b0, "R4 request stops when full", 32'(mem_req_o), 0);
        check(dec_valid_o == 1'b1, "R10 word offered while stalled", 32'(dec_valid_o), 1);
        held_pc = dec_pc_o;
        repeat (5) @(negedge clk);
        check(dec_pc_o == held_pc, "R10 head stable", dec_pc_o, held_pc);
        check(dec_pc_o == 32'h0000_3000, "R7 first word after redirect", dec_pc_o, 32'h3000);
        rdy_mode = 0;
        wait_cycles(12);

        // R2/R3: redirect while request waits without grant
        gnt_mode = 2;
        redirect(32'h0000_4000);
        wait_cycles(3);
        @(negedge clk);
        check(mem_req_o == 1'b1, "R2 request held without grant", 32'(mem_req_o), 1);
        redirect(32'h0000_5000);
        check(mem_req_o == 1'b1, "R3 request kept across redirect", 32'(mem_req_o), 1);
        @(negedge clk);
        check(mem_addr_o == 32'h0000_5000, "R2 address held", mem_addr_o, 32'h5000);
        gnt_mode = 0;
        wait_cycles(15);
        check(xfers > cnt, "R7 stream resumes", xfers, cnt);

        // R5/R7: random grants, responses, stalls and redirects
        gnt_mode = 1;
        rv_mode  = 1;
        rdy_mode = 1;
        for (int k = 0; k < 12; k++) begin
            redirect(32'h0001_0000 + 32'(k * 32'h0000_0346));
            wait_cycles(k * 7 + 3);
        end
        redirect(32'h0002_0000);
        redirect(32'h0003_0000);   // back-to-back redirects
        cnt = xfers;
        wait_cycles(200);
        check(xfers > cnt, "R5 random stream delivers", xfers, cnt);

        rv_mode = 0;
        gnt_mode = 0;
        rdy_mode = 0;
        wait_cycles(20);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule